// File: doc/BRIEF.md
# NAND Page ECC Accumulator

This block sits beside the data path of a NAND Flash controller. It watches the stream of bytes written to or read from a page and folds each byte into a Hamming-style code made of line parity and column parity. The same logic runs for writes and for reads. Software takes the code after writing a page, then re-arms the block, reads the page back and takes a second code. If the two codes match, the page is clean. If they differ, the XOR of the two codes locates a single flipped bit.

The block works only while its enable control bit is 1. A rising edge on the enable clears the code and the byte counter and samples the page-size field. Once the selected number of bytes has been folded in, the code freezes and holds until the next restart. When the enable drops, the code is held so that software can still read it.

Top module: `nand_ecc_acc`

## Requirements
- R1: After reset `ecc_code` is 0, and it stays 0 while `ecc_en` has not yet been set.
- R2: A byte is folded into the code only in a cycle where `ecc_en`=1 and `byte_valid`=1. In any other cycle `ecc_code` holds its value, including the whole time the enable is 0.
- R3: The code is a list of parity pairs. Pair i occupies bit 2i (even half) and bit 2i+1 (odd half). Pairs 0..2 are column parity for bit-position bit i: the odd half is the XOR of all data bits whose position 0..7 has bit i set, and the even half covers the remaining data bits. Pair 3+k is line parity for bit k of the byte index within the page, where the index counts from 0. For every byte whose bits XOR to 1, the odd half of pair 3+k toggles when index bit k is 1, and the even half toggles when it is 0. The updated code is visible the cycle after the byte is accepted.
- R4: `page_sel` selects the page length: 0→256, 1→512, 2→1024, 3→2048, 4→4096 and 5→8192 bytes. The values 6 and 7 also select 8192 bytes.
- R5: After the selected number of bytes has been accepted, further bytes in the same enable period are ignored and `ecc_code` holds its value.
- R6: For a page of 2^L bytes, every bit of `ecc_code` at position 2·(L+3) or above is 0.
- R7: A 0→1 transition of `ecc_en` restarts the computation. The code reads 0 from the next cycle until the first byte is accepted. A byte presented in the same cycle as the rise is taken as byte index 0 of the new page.
- R8: Take two passes over a page that differ by one flipped bit at byte B, position p. The XOR of their codes has exactly one bit set in each pair. The odd halves of pairs 0..2 spell p, and the odd halves of pairs 3 and up spell B.
- R9: `page_sel` is sampled at the enable rise. Changes to it later in the same enable period do not change the page length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Enable control bit; a rising edge restarts the code |
| page_sel | input | 3 | Encoded page length, sampled at the enable rise |
| byte_valid | input | 1 | Data strobe: `byte_data` carries a page byte this cycle |
| byte_data | input | 8 | Page byte on the NAND data path |
| ecc_code | output | 32 | Accumulated code, zero-padded above the used pairs |

## Verification
The hardest state to reach from the ports is the frozen page end on the largest sizes, together with the reserved size codes. The stimulus has to push a full 8192 bytes, with random idle gaps, before any overrun bytes can show that the code is frozen at exactly the right count. Single-bit error location needs two complete passes over an identical page. The bench gets this by generating page bytes from a hash of a seed and the byte index, XORing in one chosen bit on the second pass, and decoding the syndrome pair by pair. A restart with a byte in the same cycle as the enable rise, and a size change in the middle of a page, are driven as directed cases.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
    // Data path byte width and number of bit-position bits
    localparam int unsigned ECC_DATA_W   = 8;
    localparam int unsigned ECC_POS_W    = 3;
    // Page size range as log2 of byte count
    localparam int unsigned ECC_MIN_LOG2 = 8;
    localparam int unsigned ECC_MAX_LOG2 = 13;
    localparam int unsigned ECC_SEL_W    = 3;
    // Width of the visible result
    localparam int unsigned ECC_OUT_W    = 32;

    // Number of parity bits produced for a page of 2**log2 bytes
    function automatic int unsigned ecc_code_bits(input int unsigned log2_sz);
        return 2 * (log2_sz + ECC_POS_W);
    endfunction
endpackage

// File: rtl/nand_ecc_size_dec.sv
module nand_ecc_size_dec #(
    parameter int unsigned SEL_W    = 3,
    parameter int unsigned MIN_LOG2 = 8,
    parameter int unsigned MAX_LOG2 = 13,
    parameter int unsigned LOG_W    = $clog2(MAX_LOG2 + 1)
) (
    input  logic [SEL_W-1:0] page_sel,
    output logic [LOG_W-1:0] log2_sz
);
    localparam int unsigned SPAN = MAX_LOG2 - MIN_LOG2;

    // Codes past the largest defined size fall back to the largest size
    always_comb begin
        if (int'(page_sel) >= int'(SPAN)) begin
            log2_sz = LOG_W'(MAX_LOG2);
        end else begin
            log2_sz = LOG_W'(MIN_LOG2) + LOG_W'(page_sel);
        end
    end
endmodule

// File: rtl/nand_ecc_col_par.sv
module nand_ecc_col_par #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned POS_W  = 3
) (
    input  logic [DATA_W-1:0]  data,
    output logic [2*POS_W-1:0] col_pairs,
    output logic               byte_par
);
    assign byte_par = ^data;

    for (genvar gb = 0; gb < POS_W; gb++) begin : g_pos
        logic [DATA_W-1:0] sel_mask;
        for (genvar gj = 0; gj < DATA_W; gj++) begin : g_bit
            assign sel_mask[gj] = ((gj >> gb) & 1) != 0;
        end
        // even half covers positions with this bit clear, odd half the rest
        assign col_pairs[2*gb]   = ^(data & ~sel_mask);
        assign col_pairs[2*gb+1] = ^(data &  sel_mask);
    end
endmodule

// File: rtl/nand_ecc_line_par.sv
module nand_ecc_line_par #(
    parameter int unsigned IDX_W = 13,
    parameter int unsigned LOG_W = 4
) (
    input  logic               byte_par,
    input  logic [IDX_W-1:0]   byte_idx,
    input  logic [LOG_W-1:0]   log2_sz,
    output logic [2*IDX_W-1:0] line_pairs
);
    for (genvar gk = 0; gk < IDX_W; gk++) begin : g_line
        logic pair_on;
        // Index bits at or above the page size never take part
        assign pair_on = (log2_sz > LOG_W'(gk));
        assign line_pairs[2*gk]   = byte_par & pair_on & ~byte_idx[gk];
        assign line_pairs[2*gk+1] = byte_par & pair_on &  byte_idx[gk];
    end
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
    import nand_ecc_pkg::*;
#(
    parameter int unsigned DATA_W   = ECC_DATA_W,
    parameter int unsigned POS_W    = ECC_POS_W,
    parameter int unsigned MIN_LOG2 = ECC_MIN_LOG2,
    parameter int unsigned MAX_LOG2 = ECC_MAX_LOG2,
    parameter int unsigned SEL_W    = ECC_SEL_W,
    parameter int unsigned OUT_W    = ECC_OUT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_en,
    input  logic [SEL_W-1:0]  page_sel,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    output logic [OUT_W-1:0]  ecc_code
);
    localparam int unsigned IDX_W  = MAX_LOG2;
    localparam int unsigned CNT_W  = MAX_LOG2 + 1;
    localparam int unsigned LOG_W  = $clog2(MAX_LOG2 + 1);
    localparam int unsigned COL_W  = 2 * POS_W;
    localparam int unsigned LINE_W = 2 * IDX_W;
    localparam int unsigned CODE_W = COL_W + LINE_W;

    typedef struct packed {
        logic              en;
        logic [LOG_W-1:0]  log2_sz;
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] code;
    } acc_state_t;

    acc_state_t st_q, st_d;

    logic [LOG_W-1:0]  sel_log2;
    logic [COL_W-1:0]  col_pairs;
    logic              byte_par;
    logic [LINE_W-1:0] line_pairs;
    logic              start;
    logic [CNT_W-1:0]  base_cnt;
    logic [CODE_W-1:0] base_code;
    logic [CNT_W-1:0]  limit;
    logic              take;

    nand_ecc_size_dec #(
        .SEL_W   (SEL_W),
        .MIN_LOG2(MIN_LOG2),
        .MAX_LOG2(MAX_LOG2),
        .LOG_W   (LOG_W)
    ) u_size_dec (
        .page_sel(page_sel),
        .log2_sz (sel_log2)
    );

    nand_ecc_col_par #(
        .DATA_W(DATA_W),
        .POS_W (POS_W)
    ) u_col_par (
        .data     (byte_data),
        .col_pairs(col_pairs),
        .byte_par (byte_par)
    );

    nand_ecc_line_par #(
        .IDX_W(IDX_W),
        .LOG_W(LOG_W)
    ) u_line_par (
        .byte_par  (byte_par),
        .byte_idx  (base_cnt[IDX_W-1:0]),
        .log2_sz   (st_d.log2_sz),
        .line_pairs(line_pairs)
    );

    always_comb begin
        start     = ecc_en & ~st_q.en;
        st_d      = st_q;
        st_d.en   = ecc_en;
        if (start) begin
            st_d.log2_sz = sel_log2;
        end
        base_cnt  = start ? '0 : st_q.cnt;
        base_code = start ? '0 : st_q.code;
        limit     = CNT_W'(1) << st_d.log2_sz;
        take      = ecc_en & byte_valid & (base_cnt < limit);
        st_d.cnt  = take ? base_cnt + CNT_W'(1) : base_cnt;
        st_d.code = take ? (base_code ^ {line_pairs, col_pairs}) : base_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en      <= 1'b0;
            st_q.log2_sz <= LOG_W'(MIN_LOG2);
            st_q.cnt     <= '0;
            st_q.code    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ecc_code = OUT_W'(st_q.code);

    // Plain views of state for the bound checker
    logic              en_q;
    logic [LOG_W-1:0]  log2_q;
    logic [CNT_W-1:0]  cnt_q;
    assign en_q   = st_q.en;
    assign log2_q = st_q.log2_sz;
    assign cnt_q  = st_q.cnt;
endmodule

// File: rtl/nand_ecc_acc_chk.sv
module nand_ecc_acc_chk #(
    parameter int unsigned MIN_LOG2 = 8,
    parameter int unsigned MAX_LOG2 = 13,
    parameter int unsigned OUT_W    = 32,
    parameter int unsigned LOG_W    = 4,
    parameter int unsigned CNT_W    = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ecc_en,
    input logic             byte_valid,
    input logic [OUT_W-1:0] ecc_code,
    input logic             en_q,
    input logic [LOG_W-1:0] log2_q,
    input logic [CNT_W-1:0] cnt_q
);
    logic [CNT_W-1:0] lim;
    logic [5:0]       pad_sh;
    assign lim    = CNT_W'(1) << log2_q;
    assign pad_sh = 6'(2 * (int'(log2_q) + 3));

    assert_hold_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_en |=> $stable(ecc_code));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_en && en_q && !byte_valid) |=> $stable(ecc_code));

    assert_clear_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_en && !en_q && !byte_valid) |=> (ecc_code == '0));

    assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_en && en_q && cnt_q == lim) |=> $stable(ecc_code));

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);

    assert_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_sh >= 6'(OUT_W)) || ((ecc_code >> pad_sh) == '0));

    assert_size_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (log2_q >= LOG_W'(MIN_LOG2)) && (log2_q <= LOG_W'(MAX_LOG2)));
endmodule

bind nand_ecc_acc nand_ecc_acc_chk #(
    .MIN_LOG2(MIN_LOG2),
    .MAX_LOG2(MAX_LOG2),
    .OUT_W   (OUT_W),
    .LOG_W   (LOG_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ecc_en    (ecc_en),
    .byte_valid(byte_valid),
    .ecc_code  (ecc_code),
    .en_q      (en_q),
    .log2_q    (log2_q),
    .cnt_q     (cnt_q)
);

// File: tb/nand_ecc_acc_bench.sv
module nand_ecc_acc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_en = 1'b0;
    logic [2:0]  page_sel = 3'd0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'd0;
    logic [31:0] ecc_code;

    int unsigned tests = 0;
    int unsigned fails = 0;
    bit          done = 1'b0;
    int unsigned seed = 1;
    int          flip_idx = -1;
    logic [7:0]  flip_mask = 8'd0;

    always #5 clk = ~clk;

    nand_ecc_acc u_nand_ecc_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ecc_en    (ecc_en),
        .page_sel  (page_sel),
        .byte_valid(byte_valid),
        .byte_data (byte_data),
        .ecc_code  (ecc_code)
    );

    function automatic logic [7:0] pbyte(input int unsigned s, input int unsigned i);
        logic [31:0] x;
        x = s ^ (i * 32'h9E3779B1);
        x = x ^ (x >> 15);
        x = x * 32'h85EBCA6B;
        x = x ^ (x >> 13);
        return x[7:0] ^ x[15:8];
    endfunction

    function automatic logic [7:0] getb(input int i);
        logic [7:0] b;
        b = pbyte(seed, i);
        if (i == flip_idx) b = b ^ flip_mask;
        return b;
    endfunction

    function automatic int size_log2(input logic [2:0] sel);
        return (sel >= 3'd5) ? 13 : 8 + int'(sel);
    endfunction

    // Reference code per R3 for the first n bytes of the page
    function automatic logic [31:0] model(input int n, input int lg);
        logic [31:0] c;
        logic [7:0]  b;
        c = '0;
        for (int i = 0; i < n; i++) begin
            b = getb(i);
            for (int p = 0; p < 3; p++)
                for (int j = 0; j < 8; j++)
                    if (b[j]) begin
                        if (((j >> p) & 1) != 0) c[2*p+1] = ~c[2*p+1];
                        else                     c[2*p]   = ~c[2*p];
                    end
            if (^b)
                for (int k = 0; k < lg; k++) begin
                    if (((i >> k) & 1) != 0) c[7+2*k] = ~c[7+2*k];
                    else                     c[6+2*k] = ~c[6+2*k];
                end
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic feed(input int from, input int n);
        for (int i = from; i < n; i++) begin
            if ($urandom % 4 == 0) begin
                byte_valid = 1'b0;
                @(negedge clk);
            end
            byte_valid = 1'b1;
            byte_data  = getb(i);
            @(negedge clk);
        end
        byte_valid = 1'b0;
    endtask

    task automatic rearm(input logic [2:0] sel);
        ecc_en = 1'b0;
        @(negedge clk);
        page_sel = sel;
        ecc_en   = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_pass(input logic [2:0] sel, output logic [31:0] code);
        rearm(sel);
        feed(0, 1 << size_log2(sel));
        code = ecc_code;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp, got, held, wcode, rcode, syn;
        int          lg, n;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check(ecc_code == 0, "R1 reset value", ecc_code, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: bytes while disabled have no effect; R1 stays zero
        seed = 11;
        feed(0, 20);
        @(negedge clk);
        check(ecc_code == 0, "R1 R2 disabled bytes ignored", ecc_code, 0);

        // R3 R4 R5 R6: every size code, full page, then overrun bytes
        for (int s = 0; s < 8; s++) begin
            seed = 100 + s;
            lg   = size_log2(3'(s));
            n    = 1 << lg;
            run_pass(3'(s), got);
            exp = model(n, lg);
            check(got == exp, $sformatf("R3 R4 page code sel=%0d", s), got, exp);
            if (2 * (lg + 3) < 32)
                check((got >> (2 * (lg + 3))) == 0, "R6 padding zero", got, exp);
            seed = 900 + s;
            feed(0, 17);
            check(ecc_code == exp, "R5 overrun ignored", ecc_code, exp);
            seed = 100 + s;
        end

        // R2: dropping the enable holds the code
        held = ecc_code;
        ecc_en = 1'b0;
        repeat (3) @(negedge clk);
        check(ecc_code == held, "R2 hold while disabled", ecc_code, held);
        seed = 5;
        feed(0, 9);
        check(ecc_code == held, "R2 disabled bytes ignored", ecc_code, held);

        // R2: gaps without strobe mid-page
        seed = 31;
        rearm(3'd0);
        feed(0, 40);
        held = ecc_code;
        repeat (4) @(negedge clk);
        check(ecc_code == held, "R2 idle cycles hold", ecc_code, held);

        // R7: rise without a byte reads zero
        rearm(3'd1);
        check(ecc_code == 0, "R7 cleared after rise", ecc_code, 0);

        // R7: byte in the rise cycle counts as index 0
        seed = 77;
        ecc_en = 1'b0;
        @(negedge clk);
        page_sel   = 3'd0;
        ecc_en     = 1'b1;
        byte_valid = 1'b1;
        byte_data  = getb(0);
        @(negedge clk);
        byte_valid = 1'b0;
        exp = model(1, 8);
        check(ecc_code == exp, "R7 rise cycle byte", ecc_code, exp);
        feed(1, 256);
        exp = model(256, 8);
        check(ecc_code == exp, "R7 full page after rise byte", ecc_code, exp);

        // R9: size change mid-page is ignored
        seed = 55;
        rearm(3'd0);
        feed(0, 100);
        page_sel = 3'd3;
        feed(100, 300);
        exp = model(256, 8);
        check(ecc_code == exp, "R9 size latched at rise", ecc_code, exp);

        // R8: single-bit error location across two passes
        for (int t = 0; t < 6; t++) begin
            logic [2:0] sel;
            int bidx, bpos, didx, dpos;
            bit pairs_ok;
            sel  = (t < 3) ? 3'd0 : 3'd1;
            lg   = size_log2(sel);
            seed = 300 + t;
            flip_idx = -1;
            if (t == 0) bidx = 0;
            else if (t == 1) bidx = (1 << lg) - 1;
            else bidx = int'($urandom % (1 << lg));
            bpos = (t == 1) ? 7 : int'($urandom % 8);
            run_pass(sel, wcode);
            flip_idx  = bidx;
            flip_mask = 8'(1 << bpos);
            run_pass(sel, rcode);
            flip_idx = -1;
            syn = wcode ^ rcode;
            pairs_ok = 1'b1;
            dpos = 0;
            didx = 0;
            for (int i = 0; i < lg + 3; i++) begin
                if (syn[2*i] == syn[2*i+1]) pairs_ok = 1'b0;
                if (i < 3) dpos |= int'(syn[2*i+1]) << i;
                else       didx |= int'(syn[2*i+1]) << (i - 3);
            end
            check(pairs_ok, "R8 one bit per pair", syn, 0);
            check(didx == bidx && dpos == bpos, "R8 located byte and bit",
                  32'((didx << 3) | dpos), 32'((bidx << 3) | bpos));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule